// File: doc/BRIEF.md
# Passive LF Tag Emulation Front End

This block lets a host microcontroller act as a passive low-frequency RFID tag with traffic in both directions. It sits between the host's synchronous serial port and the coil-driver enables and peak-detector ADC of the LF analog front end. It never drives a carrier. To answer a reader, it load-modulates the antenna: one driver enable stays permanently asserted, so the coil is always weakly grounded. The remaining enables follow the host's serial data-out line. A high level leaves those drivers floating (open coil). A low level makes them pull the coil hard to ground (short coil).

To hear the reader, the block works from samples of the peak-detected antenna voltage. It has two receive paths, chosen through a small register port. In threshold mode, a comparator with separate upper and lower trip levels turns each sample into an envelope bit. That bit distinguishes full carrier from a gap or modulated carrier. It passes through two flops and then appears on the host's serial data-in line. In stream mode, each raw sample is sent to the host as an 8-bit word, most significant bit first. The block generates the serial clock, and a frame strobe is high for the first bit of each word. This lets the host firmware compute its own threshold.

Top module: `lf_tag_emu_frontend`

## Requirements
- R1: `pwr_lo` (the low-side carrier drive) is 0 in every cycle, including during and after reset.
- R2: Enable `oe_n[HOLD_IDX]` (default index 2) is 0 in every cycle.
- R3: Every other bit of `oe_n` is 1 during reset. After reset, each of these bits equals the value `ser_dout` had at the previous rising clock edge.
- R4: Reset selects threshold mode with an upper level of 0x80 and a lower level of 0x60. It also clears the envelope bit.
- R5: The envelope changes only on a cycle with `adc_valid`. A sample at or above the upper level sets it. Otherwise, a sample below the lower level clears it. Any other sample leaves it unchanged.
- R6: In threshold mode, `ser_din` shows the envelope state three clock cycles after that state was registered. Both `ser_fs` and `ser_clk` are 0 in this mode.
- R7: In stream mode, `ser_clk` repeats with a period of 2*HALF clocks (default 4): low for HALF clocks, then high for HALF clocks. Data and frame strobe change only as `ser_clk` goes low.
- R8: In stream mode, a word occupies eight consecutive serial bit periods, most significant bit first. `ser_fs` is high for the first bit period only. Between words, `ser_din` and `ser_fs` are 0.
- R9: A sample that arrives in stream mode is held in a one-word slot. It is sent at the next bit boundary where no word is in progress. A newer sample overwrites an unsent one. Samples that arrive in threshold mode are discarded, and the slot is emptied on entry to threshold mode.
- R10: A write (`cfg_we` high) to address 0 sets the upper level, address 1 sets the lower level, and address 2 sets the mode from data bit 0 (1 = stream). A write to address 3 changes nothing. Each write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW (2) | Register address |
| cfg_wdata | input | DW (8) | Register write data |
| adc_valid | input | 1 | One-cycle strobe marking a new ADC sample |
| adc_data | input | DW (8) | Peak-detector ADC sample |
| ser_dout | input | 1 | Host serial data-out; selects open or short coil |
| ser_din | output | 1 | Host serial data-in: envelope bit or sample bits |
| ser_fs | output | 1 | Frame strobe for the first bit of a sample word |
| ser_clk | output | 1 | Serial bit clock in stream mode |
| oe_n | output | NUM_OE (4) | Active-low coil driver enables |
| pwr_lo | output | 1 | Low-side carrier drive, always low |

## Verification
The hardest case to reach from the ports is a new sample arriving in the same cycle that the serializer takes the previous sample from its slot. In that cycle, the newer value must stay pending and must not be lost. A second hard case is a mode change in the middle of a word. The stimulus sends single samples whose arrival cycle is offset by each step of the serial divider phase in turn. It then sends dense bursts that overwrite the pending slot, and it flips to threshold mode partway through a word. Meanwhile, a cycle-accurate model in the bench predicts every output bit.

// File: rtl/lfte_pkg.sv
package lfte_pkg;
  typedef enum logic {
    RX_THRESH = 1'b0,
    RX_STREAM = 1'b1
  } rx_mode_e;

  localparam logic [1:0] ADDR_TH_HI = 2'd0;
  localparam logic [1:0] ADDR_TH_LO = 2'd1;
  localparam logic [1:0] ADDR_MODE  = 2'd2;
endpackage

// File: rtl/lfte_env_detect.sv
// Hysteresis comparator on peak-detector samples plus a two-flop synchronizer.
module lfte_env_detect #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp,
  input  logic [DW-1:0] th_hi,
  input  logic [DW-1:0] th_lo,
  output logic          env_raw,
  output logic          env_sync
);
  logic s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      env_raw  <= 1'b0;
      s1       <= 1'b0;
      env_sync <= 1'b0;
    end else begin
      s1       <= env_raw;
      env_sync <= s1;
      if (smp_valid) begin
        if (smp >= th_hi)      env_raw <= 1'b1;
        else if (smp < th_lo)  env_raw <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lfte_sample_tx.sv
// Serializes ADC samples MSB first with a one-bit frame strobe and a divided bit clock.
module lfte_sample_tx #(
  parameter int DW   = 8,
  parameter int HALF = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stream_en,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp,
  output logic          tx_bit,
  output logic          tx_fs,
  output logic          tx_clk
);
  localparam int BIT_CYC = 2 * HALF;
  localparam int PH_W    = (BIT_CYC > 2) ? $clog2(BIT_CYC) : 1;
  localparam int CNT_W   = $clog2(DW);

  logic [PH_W-1:0]  ph, ph_nxt;
  logic [DW-1:0]    pend, sh;
  logic             pend_v;
  logic [CNT_W-1:0] left;
  logic             last, load;

  assign last   = (ph == PH_W'(BIT_CYC - 1));
  assign ph_nxt = last ? '0 : ph + 1'b1;
  assign load   = last && pend_v && (left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= '0;
      tx_clk <= 1'b0;
      pend   <= '0;
      pend_v <= 1'b0;
      sh     <= '0;
      left   <= '0;
      tx_bit <= 1'b0;
      tx_fs  <= 1'b0;
    end else begin
      ph     <= ph_nxt;
      tx_clk <= (ph_nxt >= PH_W'(HALF));

      if (!stream_en)      pend_v <= 1'b0;
      else if (smp_valid) begin
        pend   <= smp;
        pend_v <= 1'b1;
      end else if (load)   pend_v <= 1'b0;

      if (last) begin
        if (load) begin
          tx_bit <= pend[DW-1];
          tx_fs  <= 1'b1;
          sh     <= pend << 1;
          left   <= CNT_W'(DW - 1);
        end else if (left != '0) begin
          tx_bit <= sh[DW-1];
          tx_fs  <= 1'b0;
          sh     <= sh << 1;
          left   <= left - 1'b1;
        end else begin
          tx_bit <= 1'b0;
          tx_fs  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/lfte_coil_drv.sv
// Coil driver enables: one permanently asserted, the rest follow the modulation line.
module lfte_coil_drv #(
  parameter int NUM_OE   = 4,
  parameter int HOLD_IDX = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mod_line,
  output logic [NUM_OE-1:0] oe_n,
  output logic              pwr_lo
);
  for (genvar i = 0; i < NUM_OE; i++) begin : g_oe
    logic q;
    if (i == HOLD_IDX) begin : g_hold
      always_ff @(posedge clk) q <= 1'b0;
    end else begin : g_mod
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b1;
        else     q <= mod_line;
      end
    end
    assign oe_n[i] = q;
  end

  always_ff @(posedge clk) pwr_lo <= 1'b0;
endmodule

// File: rtl/lf_tag_emu_frontend.sv
module lf_tag_emu_frontend
  import lfte_pkg::*;
#(
  parameter int          DW        = 8,
  parameter int          AW        = 2,
  parameter int          HALF      = 2,
  parameter int          NUM_OE    = 4,
  parameter int          HOLD_IDX  = 2,
  parameter logic [DW-1:0] TH_HI_RST = 8'h80,
  parameter logic [DW-1:0] TH_LO_RST = 8'h60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic              adc_valid,
  input  logic [DW-1:0]     adc_data,
  input  logic              ser_dout,
  output logic              ser_din,
  output logic              ser_fs,
  output logic              ser_clk,
  output logic [NUM_OE-1:0] oe_n,
  output logic              pwr_lo
);
  logic [DW-1:0] th_hi, th_lo;
  rx_mode_e      rx_mode;
  logic          env_raw, env_sync;
  logic          tx_bit, tx_fs, tx_clk;
  logic          stream;

  assign stream = (rx_mode == RX_STREAM);

  always_ff @(posedge clk) begin
    if (rst) begin
      th_hi   <= TH_HI_RST;
      th_lo   <= TH_LO_RST;
      rx_mode <= RX_THRESH;
    end else if (cfg_we) begin
      if (cfg_addr == AW'(ADDR_TH_HI)) th_hi   <= cfg_wdata;
      if (cfg_addr == AW'(ADDR_TH_LO)) th_lo   <= cfg_wdata;
      if (cfg_addr == AW'(ADDR_MODE))  rx_mode <= rx_mode_e'(cfg_wdata[0]);
    end
  end

  lfte_env_detect #(.DW(DW)) u_env (
    .clk(clk), .rst(rst), .smp_valid(adc_valid), .smp(adc_data),
    .th_hi(th_hi), .th_lo(th_lo), .env_raw(env_raw), .env_sync(env_sync)
  );

  lfte_sample_tx #(.DW(DW), .HALF(HALF)) u_tx (
    .clk(clk), .rst(rst), .stream_en(stream), .smp_valid(adc_valid),
    .smp(adc_data), .tx_bit(tx_bit), .tx_fs(tx_fs), .tx_clk(tx_clk)
  );

  lfte_coil_drv #(.NUM_OE(NUM_OE), .HOLD_IDX(HOLD_IDX)) u_coil (
    .clk(clk), .rst(rst), .mod_line(ser_dout), .oe_n(oe_n), .pwr_lo(pwr_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_din <= 1'b0;
      ser_fs  <= 1'b0;
      ser_clk <= 1'b0;
    end else begin
      ser_din <= stream ? tx_bit : env_sync;
      ser_fs  <= stream ? tx_fs  : 1'b0;
      ser_clk <= stream ? tx_clk : 1'b0;
    end
  end
endmodule

// File: rtl/lfte_checker.sv
module lfte_checker #(
  parameter int DW       = 8,
  parameter int AW       = 2,
  parameter int NUM_OE   = 4,
  parameter int HOLD_IDX = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              ser_dout,
  input logic [NUM_OE-1:0] oe_n,
  input logic              adc_valid,
  input logic              env_raw,
  input logic              stream,
  input logic              ser_fs,
  input logic              ser_clk,
  input logic              cfg_we,
  input logic [AW-1:0]     cfg_addr,
  input logic [DW-1:0]     th_hi,
  input logic [DW-1:0]     th_lo
);
  for (genvar i = 0; i < NUM_OE; i++) begin : g_chk
    if (i != HOLD_IDX) begin : g_mod
      a_r3_oe_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (oe_n[i] == $past(ser_dout)));
    end
  end

  a_r5_env_holds: assert property (@(posedge clk) disable iff (rst)
    !adc_valid |=> $stable(env_raw));

  a_r6_thresh_quiet: assert property (@(posedge clk) disable iff (rst)
    !stream |=> (!ser_fs && !ser_clk));

  a_r8_fs_in_stream: assert property (@(posedge clk) disable iff (rst)
    ser_fs |-> $past(stream));

  a_r10_addr3_ignored: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == AW'(3)) |=> ($stable(th_hi) && $stable(th_lo) && $stable(stream)));
endmodule

bind lf_tag_emu_frontend lfte_checker #(
  .DW(DW), .AW(AW), .NUM_OE(NUM_OE), .HOLD_IDX(HOLD_IDX)
) u_chk (
  .clk(clk), .rst(rst), .ser_dout(ser_dout), .oe_n(oe_n),
  .adc_valid(adc_valid), .env_raw(env_raw), .stream(stream),
  .ser_fs(ser_fs), .ser_clk(ser_clk), .cfg_we(cfg_we),
  .cfg_addr(cfg_addr), .th_hi(th_hi), .th_lo(th_lo)
);

// File: tb/lf_tag_emu_frontend_tb.sv
module lf_tag_emu_frontend_tb;
  localparam int HALF = 2;
  localparam int BC   = 2 * HALF;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       adc_valid = 1'b0;
  logic [7:0] adc_data = '0;
  logic       ser_dout = 1'b1;
  logic       ser_din, ser_fs, ser_clk, pwr_lo;
  logic [3:0] oe_n;

  always #5 clk = ~clk;

  lf_tag_emu_frontend u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .adc_valid(adc_valid), .adc_data(adc_data),
    .ser_dout(ser_dout), .ser_din(ser_din), .ser_fs(ser_fs),
    .ser_clk(ser_clk), .oe_n(oe_n), .pwr_lo(pwr_lo)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R4";
  bit    started = 0;
  bit    done = 0;

  // behavioural reference state
  int   m_hi, m_lo, m_ph, m_left;
  bit   m_str, m_env, m_s1, m_s2, m_pv, m_tbit, m_tfs, m_tclk, ld;
  int   m_pend, m_sh;
  bit   o_din, o_fs, o_clk;
  bit [3:0] o_oe;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_hi = 8'h80; m_lo = 8'h60; m_str = 0; m_env = 0; m_s1 = 0; m_s2 = 0;
      m_ph = 0; m_tclk = 0; m_left = 0; m_sh = 0; m_pend = 0; m_pv = 0;
      m_tbit = 0; m_tfs = 0; o_din = 0; o_fs = 0; o_clk = 0; o_oe = 4'b1011;
    end else begin
      o_din = m_str ? m_tbit : m_s2;
      o_fs  = m_str ? m_tfs : 1'b0;
      o_clk = m_str ? m_tclk : 1'b0;
      o_oe  = {ser_dout, 1'b0, ser_dout, ser_dout};
      m_s2 = m_s1;
      m_s1 = m_env;
      if (adc_valid) begin
        if (int'(adc_data) >= m_hi) m_env = 1;
        else if (int'(adc_data) < m_lo) m_env = 0;
      end
      ld = (m_ph == BC - 1) && m_pv && (m_left == 0);
      if (m_ph == BC - 1) begin
        if (ld) begin
          m_tbit = m_pend[7]; m_tfs = 1; m_sh = (m_pend << 1) & 8'hFF; m_left = 7;
        end else if (m_left != 0) begin
          m_tbit = m_sh[7]; m_tfs = 0; m_sh = (m_sh << 1) & 8'hFF; m_left--;
        end else begin
          m_tbit = 0; m_tfs = 0;
        end
      end
      m_ph = (m_ph + 1) % BC;
      m_tclk = (m_ph >= HALF);
      if (!m_str) m_pv = 0;
      else if (adc_valid) begin m_pend = adc_data; m_pv = 1; end
      else if (ld) m_pv = 0;
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: m_hi = cfg_wdata;
          2'd1: m_lo = cfg_wdata;
          2'd2: m_str = cfg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R1", "pwr_lo", pwr_lo, 0);
      chk("R2", "held enable", oe_n[2], 0);
      chk("R3", "modulated enables", {oe_n[3], oe_n[1:0]}, {o_oe[3], o_oe[1:0]});
      chk(cur_req, "ser_din", ser_din, o_din);
      chk("R8", "ser_fs", ser_fs, o_fs);
      chk("R7", "ser_clk", ser_clk, o_clk);
    end
  end

  // modulation line wanders throughout (R3)
  always @(negedge clk) ser_dout <= $urandom_range(0, 1) != 0;

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic smp(input logic [7:0] d);
    @(negedge clk);
    adc_valid = 1'b1; adc_data = d;
    @(negedge clk);
    adc_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(4);
    rst = 1'b0;
    // R4: default levels 0x80 / 0x60 in threshold mode
    cur_req = "R4";
    idle(3);
    smp(8'h80); idle(5);
    smp(8'h7F); idle(5);
    smp(8'h60); idle(5);
    smp(8'h5F); idle(5);
    smp(8'h7F); idle(5);
    // R5: hysteresis with new levels, dense and sparse samples
    cur_req = "R5";
    wr(2'd0, 8'hC0);
    wr(2'd1, 8'h40);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      adc_valid = ($urandom_range(0, 2) != 0);
      adc_data  = 8'($urandom_range(0, 255));
    end
    @(negedge clk); adc_valid = 1'b0;
    // R6: envelope visible through the sync path, serial lines quiet
    cur_req = "R6";
    smp(8'hF0); idle(6);
    smp(8'h10); idle(6);
    smp(8'hC0); idle(2);
    smp(8'h3F); idle(6);
    // R10: address 3 is ignored, levels stay in force
    cur_req = "R10";
    wr(2'd3, 8'h01);
    smp(8'hBF); idle(6);
    smp(8'hC0); idle(6);
    wr(2'd0, 8'h20);
    smp(8'h21); idle(6);
    // R8: stream mode, single samples at every divider phase offset
    cur_req = "R8";
    wr(2'd2, 8'h01);
    for (int off = 0; off < 2 * BC; off++) begin
      smp(8'($urandom_range(0, 255)));
      idle(36 + off);
    end
    smp(8'hA5); idle(40);
    smp(8'h00); idle(40);
    smp(8'hFF); idle(40);
    // R9: bursts overwrite pending slot; leave stream mode mid-word
    cur_req = "R9";
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      adc_valid = ($urandom_range(0, 3) == 0);
      adc_data  = 8'($urandom_range(0, 255));
    end
    @(negedge clk); adc_valid = 1'b0;
    smp(8'h3C); idle(6);
    wr(2'd2, 8'h00);
    smp(8'hEE); idle(10);
    wr(2'd2, 8'h01);
    idle(40);
    smp(8'h81); idle(40);
    finish_run();
  end
endmodule